// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks atomic reservations for several hardware threads. A load-linked request records, for the requesting thread, a reservation on the 16-byte aligned block that holds the given physical address. A later store-conditional from the same thread is approved only while that reservation is still held and covers the store's block. The block returns a result code, tells the memory path whether the store may proceed, and reports why a failed store was refused.

Uncacheable store-conditionals skip the reservation check and proceed with their own result code. An invalidate input drops every thread's reservation on a given block. The block also keeps a per-thread count of consecutive failed store-conditionals. It pulses a warning every tenth failure in a row and raises a sticky fatal flag when one thread reaches the failure limit, which points to a livelock in the software.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked sets the requesting thread's reservation on address bits [ADDR_W-1:4]. A later cacheable store-conditional from that thread to any byte of the same 16-byte block succeeds.
- R2: Reservations are held separately per thread ID. A load-linked or store-conditional from one thread leaves every other thread's reservation unchanged.
- R3: A cacheable store-conditional fails with result 0 and no forward when the thread holds no reservation or the block differs. sc_cause is 1 for a block mismatch on a held reservation and 0 otherwise.
- R4: Every cacheable store-conditional, whether it succeeds or fails, drops the thread's reservation.
- R5: A successful cacheable store-conditional returns result 1, forwards the store, and resets that thread's failure count to zero.
- R6: An uncacheable store-conditional returns result 2 and forwards the store. It leaves the thread's reservation and failure count unchanged.
- R7: Each failed cacheable store-conditional increments the thread's failure count. sc_warn pulses with the response when the new count is a nonzero multiple of 10.
- R8: When a thread's failure count reaches 5000, sc_fatal rises and stays high until reset. The count then holds at 5000 and raises no further warnings.
- R9: An invalidate drops the reservation of every thread whose reserved block equals the invalidate address's 16-byte block.
- R10: A store-conditional is judged on the state held before its clock edge. A load-linked for a thread in the same cycle wins over that thread's invalidate or store-conditional clear and leaves the new reservation in place.
- R11: Synchronous active-high reset clears every reservation, every count, sc_fatal and all response outputs.
- R12: The response outputs (sc_resp_valid, sc_result, sc_forward, sc_cause, sc_warn) are registered. They appear one clock after the store-conditional is presented, and sc_resp_valid is high only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-linked request this cycle |
| ll_tid | input | TW | Thread of the load-linked |
| ll_addr | input | ADDR_W | Physical address of the load-linked |
| sc_valid | input | 1 | Store-conditional request this cycle |
| sc_tid | input | TW | Thread of the store-conditional |
| sc_addr | input | ADDR_W | Physical address of the store-conditional |
| sc_uncached | input | 1 | Store-conditional targets uncacheable space |
| inv_valid | input | 1 | Invalidate request this cycle |
| inv_addr | input | ADDR_W | Address whose 16-byte block loses its reservations |
| sc_resp_valid | output | 1 | Response for the previous cycle's store-conditional |
| sc_result | output | 2 | 0 fail, 1 success, 2 uncacheable bypass |
| sc_forward | output | 1 | Store may be sent to memory |
| sc_cause | output | 1 | 1 when the failure was a block mismatch |
| sc_warn | output | 1 | Pulse on every tenth consecutive failure |
| sc_fatal | output | 1 | Sticky: failure limit reached |

## Verification
Every store-conditional result (code, forward, cause and warning) is due exactly one clock after the request. Reservation changes from load-linked, invalidate or a store-conditional take effect at that same edge, so they are seen through the next store-conditional's response. The bench advances the design one edge at a time. Before each edge it predicts the response from its behavioural model and the inputs it is about to present. It compares all outputs a short delay after the edge, in every cycle, so idle cycles also confirm that nothing is reported. The fatal flag is compared in every cycle against the model's sticky state.

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int THREADS    = 4,
  parameter int ADDR_W     = 32,
  parameter int GRAN_BITS  = 4,
  parameter int WARN_EVERY = 10,
  parameter int FAIL_LIMIT = 5000,
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ll_valid,
  input  logic [TW-1:0]     ll_tid,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              sc_valid,
  input  logic [TW-1:0]     sc_tid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic              sc_uncached,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              sc_resp_valid,
  output logic [1:0]        sc_result,
  output logic              sc_forward,
  output logic              sc_cause,
  output logic              sc_warn,
  output logic              sc_fatal
);
  localparam int BW = ADDR_W - GRAN_BITS;
  localparam int CW = $clog2(FAIL_LIMIT + 1);
  localparam int PW = (WARN_EVERY > 1) ? $clog2(WARN_EVERY) : 1;

  logic          held_q  [THREADS];
  logic [BW-1:0] block_q [THREADS];
  logic [CW-1:0] fails_q [THREADS];
  logic [PW-1:0] phase_q [THREADS];

  wire [BW-1:0] sc_block  = sc_addr[ADDR_W-1:GRAN_BITS];
  wire [BW-1:0] ll_block  = ll_addr[ADDR_W-1:GRAN_BITS];
  wire [BW-1:0] inv_block = inv_addr[ADDR_W-1:GRAN_BITS];

  wire          cached  = sc_valid && !sc_uncached;
  wire          held    = held_q[sc_tid];
  wire          match   = block_q[sc_tid] == sc_block;
  wire          pass    = cached && held && match;
  wire          fail    = cached && !(held && match);
  wire [CW-1:0] cnt     = fails_q[sc_tid];
  wire          sat     = cnt == CW'(FAIL_LIMIT);
  wire          bump    = fail && !sat;
  wire [CW-1:0] cnt_nxt = cnt + 1'b1;
  wire          wrap    = phase_q[sc_tid] == PW'(WARN_EVERY - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < THREADS; t++) begin
        held_q[t]  <= 1'b0;
        block_q[t] <= '0;
        fails_q[t] <= '0;
        phase_q[t] <= '0;
      end
      sc_resp_valid <= 1'b0;
      sc_result     <= 2'd0;
      sc_forward    <= 1'b0;
      sc_cause      <= 1'b0;
      sc_warn       <= 1'b0;
      sc_fatal      <= 1'b0;
    end else begin
      for (int t = 0; t < THREADS; t++) begin
        if (cached && sc_tid == TW'(t)) begin
          held_q[t] <= 1'b0;
          if (pass) begin
            fails_q[t] <= '0;
            phase_q[t] <= '0;
          end else if (bump) begin
            fails_q[t] <= cnt_nxt;
            phase_q[t] <= wrap ? '0 : phase_q[t] + 1'b1;
          end
        end
        if (inv_valid && block_q[t] == inv_block)
          held_q[t] <= 1'b0;
        if (ll_valid && ll_tid == TW'(t)) begin
          held_q[t]  <= 1'b1;
          block_q[t] <= ll_block;
        end
      end
      sc_resp_valid <= sc_valid;
      sc_result     <= !sc_valid ? 2'd0 : sc_uncached ? 2'd2 : pass ? 2'd1 : 2'd0;
      sc_forward    <= sc_valid && (sc_uncached || pass);
      sc_cause      <= fail && held;
      sc_warn       <= bump && wrap;
      sc_fatal      <= sc_fatal || (bump && cnt_nxt == CW'(FAIL_LIMIT));
    end
  end

  // R12
  resp_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    sc_resp_valid |-> $past(sc_valid));
  // R3
  fail_no_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_resp_valid && sc_result == 2'd0) |-> !sc_forward);
  // R5
  pass_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_resp_valid && sc_result != 2'd0) |-> (sc_forward && !sc_cause));
  // R6
  no_code3_chk: assert property (@(posedge clk) disable iff (rst)
    sc_resp_valid |-> sc_result != 2'd3);
  // R7
  warn_on_fail_chk: assert property (@(posedge clk) disable iff (rst)
    sc_warn |-> (sc_resp_valid && sc_result == 2'd0));
  // R8
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sc_fatal |=> sc_fatal);
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sc_resp_valid |-> (!sc_forward && !sc_warn && !sc_cause && sc_result == 2'd0));
endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ll_valid = 1'b0, sc_valid = 1'b0, sc_uncached = 1'b0, inv_valid = 1'b0;
  logic [1:0] ll_tid = '0, sc_tid = '0;
  logic [AW-1:0] ll_addr = '0, sc_addr = '0, inv_addr = '0;
  logic sc_resp_valid, sc_forward, sc_cause, sc_warn, sc_fatal;
  logic [1:0] sc_result;

  int checks = 0, errors = 0;
  string tag = "R11";

  int  m_held [T];
  longint m_blk [T];
  int  m_cnt [T];
  int  m_fatal;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.THREADS(T), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst),
    .ll_valid(ll_valid), .ll_tid(ll_tid), .ll_addr(ll_addr),
    .sc_valid(sc_valid), .sc_tid(sc_tid), .sc_addr(sc_addr), .sc_uncached(sc_uncached),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .sc_resp_valid(sc_resp_valid), .sc_result(sc_result), .sc_forward(sc_forward),
    .sc_cause(sc_cause), .sc_warn(sc_warn), .sc_fatal(sc_fatal));

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic cycle();
    int e_v = 0, e_res = 0, e_fwd = 0, e_cause = 0, e_warn = 0;
    int sc_hit [T];
    if (rst) begin
      for (int t = 0; t < T; t++) begin m_held[t] = 0; m_blk[t] = 0; m_cnt[t] = 0; end
      m_fatal = 0;
    end else begin
      for (int t = 0; t < T; t++) sc_hit[t] = 0;
      if (sc_valid) begin
        e_v = 1;
        if (sc_uncached) begin
          e_res = 2; e_fwd = 1;
        end else if (m_held[sc_tid] != 0 && m_blk[sc_tid] == longint'(sc_addr >> 4)) begin
          e_res = 1; e_fwd = 1; m_cnt[sc_tid] = 0; sc_hit[sc_tid] = 1;
        end else begin
          e_cause = m_held[sc_tid];
          sc_hit[sc_tid] = 1;
          if (m_cnt[sc_tid] < 5000) begin
            m_cnt[sc_tid]++;
            e_warn = (m_cnt[sc_tid] % 10 == 0);
            if (m_cnt[sc_tid] == 5000) m_fatal = 1;
          end
        end
      end
      for (int t = 0; t < T; t++) begin
        if (sc_hit[t] != 0) m_held[t] = 0;
        if (inv_valid && m_blk[t] == longint'(inv_addr >> 4)) m_held[t] = 0;
      end
      if (ll_valid) begin
        m_held[ll_tid] = 1;
        m_blk[ll_tid] = longint'(ll_addr >> 4);
      end
    end
    @(posedge clk);
    #1;
    checks++;
    if (sc_resp_valid !== 1'(e_v) || sc_result !== 2'(e_res) || sc_forward !== 1'(e_fwd) ||
        sc_cause !== 1'(e_cause) || sc_warn !== 1'(e_warn) || sc_fatal !== 1'(m_fatal)) begin
      errors++;
      $display("FAIL %s: got v=%0d res=%0d fwd=%0d cause=%0d warn=%0d fatal=%0d exp v=%0d res=%0d fwd=%0d cause=%0d warn=%0d fatal=%0d",
               tag, sc_resp_valid, sc_result, sc_forward, sc_cause, sc_warn, sc_fatal,
               e_v, e_res, e_fwd, e_cause, e_warn, m_fatal);
    end
    ll_valid = 0; sc_valid = 0; sc_uncached = 0; inv_valid = 0;
  endtask

  task automatic ll(input int tid, input logic [AW-1:0] a);
    ll_valid = 1; ll_tid = 2'(tid); ll_addr = a; cycle();
  endtask

  task automatic sc(input int tid, input logic [AW-1:0] a, input bit unc);
    sc_valid = 1; sc_tid = 2'(tid); sc_addr = a; sc_uncached = unc; cycle();
  endtask

  task automatic inv(input logic [AW-1:0] a);
    inv_valid = 1; inv_addr = a; cycle();
  endtask

  initial begin
    tag = "R11"; cycle(); cycle();
    rst = 0;
    cycle();
    sc(0, 32'h100, 0);

    tag = "R1"; ll(0, 32'h1000_0004); sc(0, 32'h1000_000C, 0);
    tag = "R4"; sc(0, 32'h1000_000C, 0);
    tag = "R3"; ll(1, 32'h2000); sc(1, 32'h2010, 0);
    sc(1, 32'h2000, 0);

    tag = "R2"; ll(0, 32'hA0); ll(1, 32'hB0); sc(1, 32'hB8, 0); sc(0, 32'hA0, 0);
    ll(2, 32'hC0); sc(3, 32'hC0, 0); sc(2, 32'hC4, 0);

    tag = "R6"; sc(2, 32'h500, 1); ll(2, 32'h500); sc(2, 32'h900, 1); sc(2, 32'h50F, 0);

    tag = "R9"; ll(0, 32'h3000); ll(1, 32'h3008); ll(2, 32'h4000);
    inv(32'h3003); sc(0, 32'h3000, 0); sc(1, 32'h3008, 0); sc(2, 32'h4000, 0);

    tag = "R10";
    ll(3, 32'h6000); ll_valid = 1; ll_tid = 2'd3; ll_addr = 32'h6000;
    inv_valid = 1; inv_addr = 32'h6004; cycle();
    sc(3, 32'h6000, 0);
    ll(3, 32'h7000);
    sc_valid = 1; sc_tid = 2'd3; sc_addr = 32'h7000; ll_valid = 1; ll_tid = 2'd3; ll_addr = 32'h7000;
    cycle();
    sc(3, 32'h7000, 0);
    cycle();

    tag = "R7";
    for (int i = 0; i < 25; i++) sc(3, 32'h8000, 0);
    tag = "R5"; ll(3, 32'h8000); sc(3, 32'h8000, 0);
    tag = "R7";
    for (int i = 0; i < 12; i++) sc(3, 32'h8000, 0);
    tag = "R6"; sc(3, 32'h8000, 1); sc(3, 32'h8000, 0);

    tag = "R8";
    for (int i = 0; i < 5010; i++) sc(0, 32'hF00, 0);
    ll(0, 32'hF00); sc(0, 32'hF00, 0); sc(1, 32'hF00, 0);

    tag = "R12"; cycle(); sc(2, 32'h0, 1); cycle();

    tag = "R11"; rst = 1; cycle(); rst = 0; cycle(); sc(1, 32'hB0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule